// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block turns a 12-bit processor address into active-low chip-select strobes for a memory map with two parts. The lower half of the map is a fixed RAM bank that is always present. The upper half is a window that one of several banks can occupy.

A single bank-choice input selects what answers in the upper half. When it is low, the processor's own banked RAM answers. When it is high, a shared option strobe is driven instead. Each option bank also has its own enable bit. Only an enabled option bank answers the shared strobe, and at most one of them does.

A sub-range at the top of the fixed bank is reserved for the character display buffer. It gets a separate strobe, so the display multiplexer can tell when the processor is touching that buffer.

The decoder is purely combinational. Every output follows the address, the valid-address qualifier and the control inputs within the same cycle.

Top module: `paged_mem_decoder`

## Requirements
- R1: When `addr_valid_i` is low, every chip-select output (`fixed_ce_n_o`, `disp_ce_n_o`, `bank_ce_n_o`, `opt_strobe_n_o`, all bits of `opt_ce_n_o`) is high (inactive) in the same cycle, whatever the other inputs are.
- R2: A valid address in 0x000..0x7FF (address bit 11 = 0) drives `fixed_ce_n_o` low, and `bank_ce_n_o`, `opt_strobe_n_o` and every `opt_ce_n_o` bit high.
- R3: A valid address in the display window 0x600..0x7FF (512 bytes) additionally drives `disp_ce_n_o` low. For any other address, `disp_ce_n_o` stays high.
- R4: A valid address in 0x800..0xFFF with `bank_sel_i` = 0 drives `bank_ce_n_o` low. `fixed_ce_n_o`, `opt_strobe_n_o` and all `opt_ce_n_o` bits stay high.
- R5: A valid address in 0x800..0xFFF with `bank_sel_i` = 1 drives `opt_strobe_n_o` low. `fixed_ce_n_o` and `bank_ce_n_o` stay high.
- R6: While `opt_strobe_n_o` is low and exactly one bit i of `opt_en_i` is 1, `opt_ce_n_o[i]` is low and every other bit of `opt_ce_n_o` is high.
- R7: While `opt_strobe_n_o` is low and several `opt_en_i` bits are 1, only the bit of `opt_ce_n_o` with the lowest index among them goes low.
- R8: While `opt_en_i` is all zero, every bit of `opt_ce_n_o` stays high, even when `opt_strobe_n_o` is low.
- R9: `opt_conflict_o` is 1 exactly when two or more bits of `opt_en_i` are 1, independent of the address and the qualifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 12 | Processor address |
| addr_valid_i | input | 1 | Address qualifier, high while `addr_i` is valid |
| bank_sel_i | input | 1 | Upper-half owner: 0 = processor bank, 1 = option banks |
| opt_en_i | input | 4 | One enable bit per option bank |
| fixed_ce_n_o | output | 1 | Active-low select of the fixed lower bank |
| disp_ce_n_o | output | 1 | Active-low select of the display buffer window |
| bank_ce_n_o | output | 1 | Active-low select of the processor banked RAM |
| opt_strobe_n_o | output | 1 | Shared active-low option strobe |
| opt_ce_n_o | output | 4 | Per-option active-low selects |
| opt_conflict_o | output | 1 | More than one option enable bit is set |

## Verification
The bench goes after the edges between regions: 0x5FF/0x600 for the display window and 0x7FF/0x800 for the half split. A decoder with a shifted comparison would select the wrong bank on exactly one of those addresses.

For the option banks, every combination of enable bits is tried with both settings of the bank-choice input. A broken priority chain would assert two option selects at once, or pick the highest enabled bank instead of the lowest.

The bench also drops the qualifier on upper-half addresses with enables set. A design that forgot to gate the option path with the qualifier would leave an option select active on an invalid bus cycle.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  // Returns 1 when addr lies in [base, base+size).
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (addr >= base) && (addr < base + size);
  endfunction

  // Upper half of an address space of width aw.
  function automatic logic upper_half(input logic [31:0] addr, input int aw);
    return addr[aw-1];
  endfunction

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_FIXED = 2'd1,
    RGN_BANK  = 2'd2,
    RGN_OPT   = 2'd3
  } region_e;

endpackage

// File: rtl/pmd_region_decode.sv
module pmd_region_decode
  import pmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DISP_BASE  = 'h600,
  parameter int DISP_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              bank_sel,
  output region_e           region,
  output logic              disp_hit
);
  logic [31:0] addr_ext;
  logic        hi;

  assign addr_ext = 32'(addr);
  assign hi       = upper_half(addr_ext, ADDR_W);

  always_comb begin
    region = RGN_NONE;
    if (valid) begin
      if (!hi)           region = RGN_FIXED;
      else if (bank_sel) region = RGN_OPT;
      else               region = RGN_BANK;
    end
  end

  assign disp_hit = valid && !hi &&
                    in_window(addr_ext, 32'(DISP_BASE), 32'(DISP_BYTES));
endmodule

// File: rtl/pmd_option_arbiter.sv
module pmd_option_arbiter #(
  parameter int NUM_OPT = 4
) (
  input  logic [NUM_OPT-1:0] en,
  input  logic               strobe,
  output logic [NUM_OPT-1:0] grant,
  output logic               conflict
);
  logic [NUM_OPT:0]   taken;
  logic [NUM_OPT-1:0] dup;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM_OPT; i++) begin : g_chain
    assign grant[i]    = strobe && en[i] && !taken[i];
    assign dup[i]      = en[i] && taken[i];
    assign taken[i+1]  = taken[i] || en[i];
  end

  assign conflict = |dup;
endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
  import pmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_OPT    = 4,
  parameter int DISP_BASE  = 'h600,
  parameter int DISP_BYTES = 512
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               addr_valid_i,
  input  logic               bank_sel_i,
  input  logic [NUM_OPT-1:0] opt_en_i,
  output logic               fixed_ce_n_o,
  output logic               disp_ce_n_o,
  output logic               bank_ce_n_o,
  output logic               opt_strobe_n_o,
  output logic [NUM_OPT-1:0] opt_ce_n_o,
  output logic               opt_conflict_o
);
  region_e            region;
  logic               disp_hit;
  logic               opt_active;
  logic [NUM_OPT-1:0] opt_grant;

  pmd_region_decode #(
    .ADDR_W(ADDR_W), .DISP_BASE(DISP_BASE), .DISP_BYTES(DISP_BYTES)
  ) u_region (
    .addr(addr_i), .valid(addr_valid_i), .bank_sel(bank_sel_i),
    .region(region), .disp_hit(disp_hit)
  );

  assign opt_active = (region == RGN_OPT);

  pmd_option_arbiter #(.NUM_OPT(NUM_OPT)) u_arb (
    .en(opt_en_i), .strobe(opt_active),
    .grant(opt_grant), .conflict(opt_conflict_o)
  );

  assign fixed_ce_n_o   = !(region == RGN_FIXED);
  assign bank_ce_n_o    = !(region == RGN_BANK);
  assign opt_strobe_n_o = !opt_active;
  assign disp_ce_n_o    = !disp_hit;
  assign opt_ce_n_o     = ~opt_grant;
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker #(
  parameter int ADDR_W  = 12,
  parameter int NUM_OPT = 4
) (
  input logic [ADDR_W-1:0]  addr_i,
  input logic               addr_valid_i,
  input logic               bank_sel_i,
  input logic [NUM_OPT-1:0] opt_en_i,
  input logic               fixed_ce_n_o,
  input logic               disp_ce_n_o,
  input logic               bank_ce_n_o,
  input logic               opt_strobe_n_o,
  input logic [NUM_OPT-1:0] opt_ce_n_o
);
  always_comb begin
    if (!addr_valid_i)
      assert_idle_when_invalid_R1: assert (fixed_ce_n_o && disp_ce_n_o && bank_ce_n_o
                                           && opt_strobe_n_o && (&opt_ce_n_o));
    if (addr_valid_i && !addr_i[ADDR_W-1])
      assert_low_half_fixed_R2: assert (!fixed_ce_n_o && bank_ce_n_o && opt_strobe_n_o);
    if (!disp_ce_n_o)
      assert_disp_inside_fixed_R3: assert (!fixed_ce_n_o);
    if (addr_valid_i && addr_i[ADDR_W-1] && !bank_sel_i)
      assert_bank_path_R4: assert (!bank_ce_n_o && opt_strobe_n_o);
    if (!(&opt_ce_n_o))
      assert_opt_needs_strobe_R5: assert (!opt_strobe_n_o);
    assert_opt_single_R7: assert ($onehot0(~opt_ce_n_o));
    assert_opt_enabled_only_R8: assert (((~opt_ce_n_o) & ~opt_en_i) == '0);
  end
endmodule

bind paged_mem_decoder pmd_checker #(.ADDR_W(ADDR_W), .NUM_OPT(NUM_OPT)) u_chk (
  .addr_i(addr_i), .addr_valid_i(addr_valid_i), .bank_sel_i(bank_sel_i),
  .opt_en_i(opt_en_i), .fixed_ce_n_o(fixed_ce_n_o), .disp_ce_n_o(disp_ce_n_o),
  .bank_ce_n_o(bank_ce_n_o), .opt_strobe_n_o(opt_strobe_n_o), .opt_ce_n_o(opt_ce_n_o)
);

// File: tb/paged_mem_decoder_tb.sv
module paged_mem_decoder_tb;
  localparam int AW = 12;
  localparam int NO = 4;

  logic          clk = 1'b0;
  logic [AW-1:0] addr;
  logic          valid;
  logic          bsel;
  logic [NO-1:0] en;
  logic          fixed_n, disp_n, bank_n, strobe_n, conflict;
  logic [NO-1:0] opt_n;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  paged_mem_decoder u_dut (
    .addr_i(addr), .addr_valid_i(valid), .bank_sel_i(bsel), .opt_en_i(en),
    .fixed_ce_n_o(fixed_n), .disp_ce_n_o(disp_n), .bank_ce_n_o(bank_n),
    .opt_strobe_n_o(strobe_n), .opt_ce_n_o(opt_n), .opt_conflict_o(conflict)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h v=%b sel=%b en=%b actual=%b expected=%b",
               req, addr, valid, bsel, en, act, exp);
    end
  endtask

  // Apply one input set, settle, compare all outputs with a model.
  task automatic apply(input int a, input bit v, input bit s, input int e);
    int     ucnt;
    bit     hi, dw;
    logic [NO-1:0] pick;
    logic [8:0] exp;
    string  tag;
    addr = AW'(a); valid = v; bsel = s; en = NO'(e);
    #1;
    hi   = (a >= 2048);
    dw   = (a >= 1536) && (a < 2048);
    pick = NO'(e & ((~e) + 1));          // lowest set bit
    ucnt = $countones(NO'(e));
    exp[8] = !(v && !hi);                // fixed
    exp[7] = !(v && dw);                 // display
    exp[6] = !(v && hi && !s);           // processor bank
    exp[5] = !(v && hi && s);            // option strobe
    exp[4:1] = (v && hi && s) ? ~pick : 4'hF;
    exp[0] = (ucnt >= 2);
    if (!v)              tag = "R1";
    else if (!hi)        tag = dw ? "R3" : "R2";
    else if (!s)         tag = "R4";
    else if (ucnt == 0)  tag = "R8";
    else if (ucnt == 1)  tag = "R6";
    else                 tag = "R7";
    check(tag, {fixed_n, disp_n, bank_n, strobe_n, opt_n, conflict}, exp);
    if (v && hi && s)
      check("R5", {8'h00, strobe_n}, 9'd0);
    check("R9", {8'h00, conflict}, {8'h00, exp[0]});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    // Reset state: qualifier low (R1)
    apply(0, 0, 0, 0);
    apply(12'hFFF, 0, 1, 4'hF);
    // Region boundaries (R2, R3, R4, R5)
    apply(12'h5FF, 1, 0, 0);
    apply(12'h600, 1, 0, 0);
    apply(12'h7FF, 1, 1, 1);
    apply(12'h800, 1, 0, 1);
    apply(12'h800, 1, 1, 4'b0110);
    // Same-cycle drop of the qualifier on an option access (R1)
    apply(12'hA00, 1, 1, 4'b0100);
    apply(12'hA00, 0, 1, 4'b0100);
    // Full address sweep with every enable pattern and bank choice
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 16; e++)
        for (int a = 0; a < 4096; a += 1 + (e % 3)) begin
          apply(a, 1, s[0], e);
          if (a % 256 == 7) apply(a, 0, s[0], e);
        end
    finish_up();
  end
endmodule